// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of taking a processor exception in a 64-bit control coprocessor. An exception request arrives as a one-cycle pulse with an encoded cause, the PC of the faulting instruction, a flag that marks a branch delay slot, the faulting virtual address and a capability base offset. On the next clock edge the block records the return PC and the branch-delay bit, writes the exception code into the Cause word, raises the exception-level bit in Status, fills the bad-address and translation context fields for address-related causes, and presents a redirected fetch address for one cycle.

The block also decodes the current privilege level from Status. When an access to the control coprocessor is made outside kernel level while the coprocessor-0 usable bit is clear, it raises a coprocessor-unusable exception on its own. A small write port seeds the Status and Cause words. The rest of the pipeline owns fetch, translation lookup, interrupt arbitration and exception return.

Top module: `exc_entry_ctrl`

## Requirements
- R1: `req_cause` uses this 5-bit encoding, with the exception code written on entry in brackets. 0 interrupt (0x00). 1 syscall (0x08). 2 breakpoint (0x09). 3 reserved instruction (0x0A). 4 overflow (0x0C). 5 trap (0x0D). 6 coprocessor unusable (0x0B). 7 address error on load (0x04). 8 address error on store (0x05). 9 TLB modify (0x01). 10 TLB load (0x02). 11 TLB store (0x03). 12 refill load (0x02). 13 refill store (0x03). 14 invalid load (0x02). 15 invalid store (0x03). 16 coprocessor-2 error (0x12). 17 capability trap (0x12). 18 machine check (0x18).
- R2: An accepted exception writes its code into Cause[6:2] and sets Status[1] (EXL). In the cycle after the request, `redir_valid` is high for exactly one cycle with `redir_pc`, and all register updates become visible in that same cycle. `req_accept` echoes `req_valid`.
- R3: When EXL is clear at the request, the exception PC becomes PC−4 with Cause[31] (BD) set if the instruction is in a delay slot. Otherwise it becomes PC with BD cleared.
- R4: When EXL is already set at the request, the exception PC and BD keep their values.
- R5: The vector offset is 0x180 when EXL is already set. When EXL is clear, it is 0x080 for causes 12 and 13, 0x280 for cause 17, and 0x180 for all other causes.
- R6: The vector base is 0xFFFFFFFF_BFC00200 when Status[22] (BEV) is 1 and 0xFFFFFFFF_80000000 when it is 0. `redir_pc` = base + offset − `cap_base`, taken modulo 2^64.
- R7: For causes 9 to 15, the bad-address register takes the faulting address. The context, extended-context and entry-high fields take the following address slices: ctx_badvpn2 = addr[31:13], xctx_badvpn2 = addr[39:13], xctx_r = addr[63:62], entryhi_r = addr[63:62], entryhi_vpn2 = addr[39:13]. Causes 7 and 8 update only the bad-address register. All other causes leave all of these unchanged.
- R8: `priv_level` is 0 (kernel) whenever Status[1] (EXL) or Status[2] (ERL) is set. Otherwise it follows Status[4:3]: 00 gives 0 (kernel), 01 gives 1 (supervisor), and 10 or 11 give 2 (user).
- R9: A `cp0_access` pulse made at a level other than kernel while Status[28] (CU0) is 0 raises cause 6 using `req_pc` and `req_in_delay`, and clears Cause[29:28] (CE). At kernel level, or when CU0 is 1, the pulse produces no redirect.
- R10: When `req_valid` and a violating `cp0_access` occur in the same cycle, the external request is taken with its own cause, and CE is not cleared.
- R11: Bits of Cause other than 31, 29:28 and 6:2, and all bits of Status other than bit 1, keep their values across exception entry.
- R12: Reset leaves Status = 0x0040_0000 (BEV set, EXL clear), Cause = 0, the exception PC = 0 and `redir_valid` low.
- R13: `cp0_wr_en` writes `cp0_wr_data` into Status when `cp0_wr_sel` is 1 and into Cause when it is 0, visible in the next cycle. A write in the same cycle as an exception entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle exception request |
| req_accept | output | 1 | Request taken this cycle |
| req_cause | input | 5 | Encoded cause (R1) |
| req_pc | input | 64 | PC of the faulting instruction |
| req_in_delay | input | 1 | Instruction sits in a branch delay slot |
| req_badaddr | input | 64 | Faulting virtual address |
| cap_base | input | 64 | Capability base subtracted from the target |
| cp0_access | input | 1 | Instruction touches coprocessor 0 this cycle |
| cp0_wr_en | input | 1 | Seed write strobe |
| cp0_wr_sel | input | 1 | 1 selects Status, 0 selects Cause |
| cp0_wr_data | input | 32 | Seed write data |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | 64 | Exception vector address |
| epc | output | 64 | Saved exception PC |
| cause | output | 32 | Cause word |
| status | output | 32 | Status word |
| badvaddr | output | 64 | Bad virtual address |
| ctx_badvpn2 | output | 19 | Context bad page field |
| xctx_badvpn2 | output | 27 | Extended context bad page field |
| xctx_r | output | 2 | Extended context region field |
| entryhi_r | output | 2 | Entry-high region field |
| entryhi_vpn2 | output | 27 | Entry-high page field |
| priv_level | output | 2 | Decoded privilege level (R8) |

## Verification
The assertions run on every cycle. They tie each redirect pulse to exactly one accepted entry, require EXL to be set afterwards, and hold the saved PC and BD steady when entry happens at exception level. They also check the untouched Cause bits across entry, the kernel decode while EXL or ERL is set, and the code and CE clearing of a self-raised coprocessor-unusable exception. Only the bench scenarios can show the exact vector arithmetic under each base, offset and capability base, including wrap-around. The same holds for the per-cause code table, the address slices copied into the translation fields, the delay-slot PC adjustment, the priority of an external request over an access violation, and the dropping of seed writes that collide with entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XLEN   = 64;
  localparam int CODE_W = 5;

  // Status bit positions
  localparam int ST_CU0 = 28;
  localparam int ST_BEV = 22;
  localparam int ST_KSU = 3;
  localparam int ST_ERL = 2;
  localparam int ST_EXL = 1;

  // Cause bit positions
  localparam int CA_BD   = 31;
  localparam int CA_CE   = 28;
  localparam int CA_CODE = 2;

  typedef enum logic [4:0] {
    EXC_INT       = 5'd0,
    EXC_SYSCALL   = 5'd1,
    EXC_BREAK     = 5'd2,
    EXC_RESV      = 5'd3,
    EXC_OVF       = 5'd4,
    EXC_TRAP      = 5'd5,
    EXC_COPU      = 5'd6,
    EXC_ADDR_LD   = 5'd7,
    EXC_ADDR_ST   = 5'd8,
    EXC_TLB_MOD   = 5'd9,
    EXC_TLB_LD    = 5'd10,
    EXC_TLB_ST    = 5'd11,
    EXC_REFILL_LD = 5'd12,
    EXC_REFILL_ST = 5'd13,
    EXC_INVAL_LD  = 5'd14,
    EXC_INVAL_ST  = 5'd15,
    EXC_CP2_ERR   = 5'd16,
    EXC_CAP_TRAP  = 5'd17,
    EXC_MCHECK    = 5'd18
  } exc_cause_e;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2
  } priv_e;

  function automatic logic [CODE_W-1:0] exc_code(input logic [4:0] c);
    case (c)
      EXC_INT:                    return 5'h00;
      EXC_TLB_MOD:                return 5'h01;
      EXC_TLB_LD, EXC_REFILL_LD,
      EXC_INVAL_LD:               return 5'h02;
      EXC_TLB_ST, EXC_REFILL_ST,
      EXC_INVAL_ST:               return 5'h03;
      EXC_ADDR_LD:                return 5'h04;
      EXC_ADDR_ST:                return 5'h05;
      EXC_SYSCALL:                return 5'h08;
      EXC_BREAK:                  return 5'h09;
      EXC_RESV:                   return 5'h0A;
      EXC_COPU:                   return 5'h0B;
      EXC_OVF:                    return 5'h0C;
      EXC_TRAP:                   return 5'h0D;
      EXC_CP2_ERR, EXC_CAP_TRAP:  return 5'h12;
      default:                    return 5'h18;
    endcase
  endfunction

  function automatic logic is_tlb_class(input logic [4:0] c);
    return (c >= EXC_TLB_MOD) && (c <= EXC_INVAL_ST);
  endfunction

  function automatic logic is_addr_err(input logic [4:0] c);
    return (c == EXC_ADDR_LD) || (c == EXC_ADDR_ST);
  endfunction

endpackage

// File: rtl/exc_priv_decode.sv
module exc_priv_decode
  import exc_pkg::*;
(
  input  logic       exl,
  input  logic       erl,
  input  logic [1:0] ksu,
  input  logic       cu0,
  input  logic       cp0_access,
  output logic [1:0] priv,
  output logic       viol
);

  always_comb begin
    if (exl || erl) begin
      priv = PRIV_KERNEL;
    end else begin
      case (ksu)
        2'b00:   priv = PRIV_KERNEL;
        2'b01:   priv = PRIV_SUPER;
        default: priv = PRIV_USER;
      endcase
    end
  end

  assign viol = cp0_access && (priv != PRIV_KERNEL) && !cu0;

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_pkg::*;
#(
  parameter int              AW          = 64,
  parameter int              OFF_W       = 12,
  parameter logic [AW-1:0]   BASE_BOOT   = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [AW-1:0]   BASE_NORM   = 64'hFFFF_FFFF_8000_0000,
  parameter logic [OFF_W-1:0] OFF_COMMON = 12'h180,
  parameter logic [OFF_W-1:0] OFF_REFILL = 12'h080,
  parameter logic [OFF_W-1:0] OFF_CAP    = 12'h280
) (
  input  logic [4:0]    cause_sel,
  input  logic          exl,
  input  logic          bev,
  input  logic [AW-1:0] cap_base,
  output logic [AW-1:0] target
);

  localparam int EXT_W = AW - OFF_W;

  function automatic logic [OFF_W-1:0] pick_offset(input logic [4:0] c, input logic at_exl);
    if (at_exl)                                       return OFF_COMMON;
    if (c == EXC_REFILL_LD || c == EXC_REFILL_ST)     return OFF_REFILL;
    if (c == EXC_CAP_TRAP)                            return OFF_CAP;
    return OFF_COMMON;
  endfunction

  function automatic logic [AW-1:0] vector_addr(input logic [AW-1:0] base,
                                                input logic [OFF_W-1:0] off,
                                                input logic [AW-1:0] cb);
    return base + {{EXT_W{off[OFF_W-1]}}, off} - cb;
  endfunction

  logic [OFF_W-1:0] off_sel;
  logic [AW-1:0]    base_sel;

  assign off_sel  = pick_offset(cause_sel, exl);
  assign base_sel = bev ? BASE_BOOT : BASE_NORM;
  assign target   = vector_addr(base_sel, off_sel, cap_base);

endmodule

// File: rtl/exc_cp0_state.sv
module exc_cp0_state
  import exc_pkg::*;
#(
  parameter int            AW        = 64,
  parameter logic [31:0]   STATUS_RST = 32'h0040_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [4:0]    eff_cause,
  input  logic          clear_ce,
  input  logic [AW-1:0] pc,
  input  logic          in_delay,
  input  logic [AW-1:0] badaddr,
  input  logic [AW-1:0] target,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [31:0]   wr_data,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic [AW-1:0] epc,
  output logic [31:0]   cause,
  output logic [31:0]   status,
  output logic [AW-1:0] badvaddr,
  output logic [18:0]   ctx_badvpn2,
  output logic [26:0]   xctx_badvpn2,
  output logic [1:0]    xctx_r,
  output logic [1:0]    entryhi_r,
  output logic [26:0]   entryhi_vpn2
);

  logic at_exl;
  logic upd_tlb;
  logic upd_bad;

  assign at_exl  = status[ST_EXL];
  assign upd_tlb = is_tlb_class(eff_cause);
  assign upd_bad = upd_tlb || is_addr_err(eff_cause);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid  <= 1'b0;
      redir_pc     <= '0;
      epc          <= '0;
      cause        <= '0;
      status       <= STATUS_RST;
      badvaddr     <= '0;
      ctx_badvpn2  <= '0;
      xctx_badvpn2 <= '0;
      xctx_r       <= '0;
      entryhi_r    <= '0;
      entryhi_vpn2 <= '0;
    end else begin
      redir_valid <= take;
      if (take) begin
        redir_pc <= target;
        if (!at_exl) begin
          epc          <= in_delay ? (pc - AW'(4)) : pc;
          cause[CA_BD] <= in_delay;
        end
        cause[CA_CODE +: CODE_W] <= exc_code(eff_cause);
        if (clear_ce) cause[CA_CE +: 2] <= 2'b00;
        status[ST_EXL] <= 1'b1;
        if (upd_bad) badvaddr <= badaddr;
        if (upd_tlb) begin
          ctx_badvpn2  <= badaddr[31:13];
          xctx_badvpn2 <= badaddr[39:13];
          xctx_r       <= badaddr[63:62];
          entryhi_r    <= badaddr[63:62];
          entryhi_vpn2 <= badaddr[39:13];
        end
      end else if (wr_en) begin
        if (wr_sel) status <= wr_data;
        else        cause  <= wr_data;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_accept,
  input  logic [4:0]    req_cause,
  input  logic [AW-1:0] req_pc,
  input  logic          req_in_delay,
  input  logic [AW-1:0] req_badaddr,
  input  logic [AW-1:0] cap_base,
  input  logic          cp0_access,
  input  logic          cp0_wr_en,
  input  logic          cp0_wr_sel,
  input  logic [31:0]   cp0_wr_data,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic [AW-1:0] epc,
  output logic [31:0]   cause,
  output logic [31:0]   status,
  output logic [AW-1:0] badvaddr,
  output logic [18:0]   ctx_badvpn2,
  output logic [26:0]   xctx_badvpn2,
  output logic [1:0]    xctx_r,
  output logic [1:0]    entryhi_r,
  output logic [26:0]   entryhi_vpn2,
  output logic [1:0]    priv_level
);

  // internal events, named for the checker
  logic       cp0_viol;
  logic       take;
  logic       clear_ce;
  logic [4:0] eff_cause;
  logic [AW-1:0] target;

  exc_priv_decode u_priv (
    .exl        (status[ST_EXL]),
    .erl        (status[ST_ERL]),
    .ksu        (status[ST_KSU +: 2]),
    .cu0        (status[ST_CU0]),
    .cp0_access (cp0_access),
    .priv       (priv_level),
    .viol       (cp0_viol)
  );

  // external request wins over a same-cycle access violation
  assign take       = req_valid || cp0_viol;
  assign clear_ce   = cp0_viol && !req_valid;
  assign eff_cause  = req_valid ? req_cause : EXC_COPU;
  assign req_accept = req_valid;

  exc_target_calc #(.AW(AW)) u_tgt (
    .cause_sel (eff_cause),
    .exl       (status[ST_EXL]),
    .bev       (status[ST_BEV]),
    .cap_base  (cap_base),
    .target    (target)
  );

  exc_cp0_state #(.AW(AW)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .eff_cause    (eff_cause),
    .clear_ce     (clear_ce),
    .pc           (req_pc),
    .in_delay     (req_in_delay),
    .badaddr      (req_badaddr),
    .target       (target),
    .wr_en        (cp0_wr_en),
    .wr_sel       (cp0_wr_sel),
    .wr_data      (cp0_wr_data),
    .redir_valid  (redir_valid),
    .redir_pc     (redir_pc),
    .epc          (epc),
    .cause        (cause),
    .status       (status),
    .badvaddr     (badvaddr),
    .ctx_badvpn2  (ctx_badvpn2),
    .xctx_badvpn2 (xctx_badvpn2),
    .xctx_r       (xctx_r),
    .entryhi_r    (entryhi_r),
    .entryhi_vpn2 (entryhi_vpn2)
  );

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        cp0_viol,
  input logic        take,
  input logic        redir_valid,
  input logic [31:0] status,
  input logic [31:0] cause,
  input logic [63:0] epc,
  input logic [1:0]  priv_level
);

  localparam logic [31:0] KEEP_MASK = 32'h4FFF_FF83;

  // R2
  redir_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> redir_valid);

  // R2
  no_spurious_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !redir_valid);

  // R2
  exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> status[1]);

  // R4
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && status[1]) |=> ($stable(epc) && $stable(cause[31])));

  // R11
  cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((cause & KEEP_MASK) == ($past(cause) & KEEP_MASK)));

  // R8
  kernel_at_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] || status[2]) |-> (priv_level == 2'd0));

  // R9
  copu_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp0_viol && !req_valid) |=> ((cause[6:2] == 5'h0B) && (cause[29:28] == 2'b00)));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .cp0_viol    (cp0_viol),
  .take        (take),
  .redir_valid (redir_valid),
  .status      (status),
  .cause       (cause),
  .epc         (epc),
  .priv_level  (priv_level)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

  localparam time CLK_HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_accept;
  logic [4:0]  req_cause = '0;
  logic [63:0] req_pc = '0;
  logic        req_in_delay = 1'b0;
  logic [63:0] req_badaddr = '0;
  logic [63:0] cap_base = '0;
  logic        cp0_access = 1'b0;
  logic        cp0_wr_en = 1'b0;
  logic        cp0_wr_sel = 1'b0;
  logic [31:0] cp0_wr_data = '0;
  logic        redir_valid;
  logic [63:0] redir_pc, epc, badvaddr;
  logic [31:0] cause, status;
  logic [18:0] ctx_badvpn2;
  logic [26:0] xctx_badvpn2, entryhi_vpn2;
  logic [1:0]  xctx_r, entryhi_r, priv_level;

  always #(CLK_HALF) clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (.*);

  typedef struct {
    logic [63:0] pc, epc, bad;
    logic [31:0] cause, status;
    logic [18:0] cbv;
    logic [26:0] xbv, vpn;
    logic [1:0]  xr, hr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // bench-side model of the architectural state
  logic [63:0] m_epc, m_bad;
  logic [31:0] m_cause, m_status;
  logic [18:0] m_cbv;
  logic [26:0] m_xbv, m_vpn;
  logic [1:0]  m_xr, m_hr;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [4:0] tb_code(input int c);
    logic [4:0] t [0:18] = '{5'h00, 5'h08, 5'h09, 5'h0A, 5'h0C, 5'h0D, 5'h0B, 5'h04, 5'h05,
                             5'h01, 5'h02, 5'h03, 5'h02, 5'h03, 5'h02, 5'h03, 5'h12, 5'h12, 5'h18};
    return t[c];
  endfunction

  function automatic logic [1:0] tb_priv();
    if (m_status[1] | m_status[2]) return 2'd0;
    if (m_status[4:3] == 2'b00) return 2'd0;
    if (m_status[4:3] == 2'b01) return 2'd1;
    return 2'd2;
  endfunction

  task automatic model_reset();
    m_epc = '0; m_bad = '0; m_cause = '0; m_status = 32'h0040_0000;
    m_cbv = '0; m_xbv = '0; m_vpn = '0; m_xr = '0; m_hr = '0;
    q.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic drive(input bit req, input int c, input logic [63:0] pc, input bit dly,
                       input logic [63:0] bad, input logic [63:0] cb, input bit acc,
                       input bit wr, input bit wsel, input logic [31:0] wdata, input string tag);
    bit viol, tk;
    int ec;
    logic [63:0] base, off;
    exp_t e;
    @(negedge clk);
    req_valid = req; req_cause = 5'(c); req_pc = pc; req_in_delay = dly;
    req_badaddr = bad; cap_base = cb; cp0_access = acc;
    cp0_wr_en = wr; cp0_wr_sel = wsel; cp0_wr_data = wdata;
    viol = acc && (tb_priv() != 2'd0) && !m_status[28];
    tk = req || viol;
    ec = req ? c : 6;
    if (tk) begin
      base = m_status[22] ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
      if (m_status[1])            off = 64'h180;
      else if (ec == 12 || ec == 13) off = 64'h080;
      else if (ec == 17)          off = 64'h280;
      else                        off = 64'h180;
      if (!m_status[1]) begin
        m_epc = dly ? pc - 64'd4 : pc;
        m_cause[31] = dly;
      end
      m_cause[6:2] = tb_code(ec);
      if (!req) m_cause[29:28] = 2'b00;
      m_status[1] = 1'b1;
      if (ec >= 7 && ec <= 15) m_bad = bad;
      if (ec >= 9 && ec <= 15) begin
        m_cbv = bad[31:13]; m_xbv = bad[39:13]; m_xr = bad[63:62];
        m_hr = bad[63:62]; m_vpn = bad[39:13];
      end
      e.pc = base + off - cb; e.epc = m_epc; e.bad = m_bad; e.cause = m_cause;
      e.status = m_status; e.cbv = m_cbv; e.xbv = m_xbv; e.vpn = m_vpn;
      e.xr = m_xr; e.hr = m_hr; e.tag = tag;
      q.push_back(e);
    end else if (wr) begin
      if (wsel) m_status = wdata; else m_cause = wdata;
    end
    @(negedge clk);
    req_valid = 1'b0; cp0_access = 1'b0; cp0_wr_en = 1'b0;
  endtask

  task automatic exc(input int c, input logic [63:0] pc, input bit dly,
                     input logic [63:0] bad, input logic [63:0] cb, input string tag);
    drive(1'b1, c, pc, dly, bad, cb, 1'b0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    drive(1'b0, 0, 64'h0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1, sel, d, "R13");
  endtask

  task automatic acc(input logic [63:0] pc, input string tag);
    drive(1'b0, 0, pc, 1'b0, 64'h0, 64'h0, 1'b1, 1'b0, 1'b0, 32'h0, tag);
  endtask

  // monitor: pops and compares on each redirect
  always @(posedge clk) begin
    #2;
    if (rst_n && !done && redir_valid) begin
      if (q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R9 actual=redirect expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " R6 redir_pc"}, redir_pc, e.pc);
        chk({e.tag, " R3 epc"}, epc, e.epc);
        chk({e.tag, " R2 cause"}, {32'h0, cause}, {32'h0, e.cause});
        chk({e.tag, " R2 status"}, {32'h0, status}, {32'h0, e.status});
        chk({e.tag, " R7 badvaddr"}, badvaddr, e.bad);
        chk({e.tag, " R7 ctx"}, {45'h0, ctx_badvpn2}, {45'h0, e.cbv});
        chk({e.tag, " R7 xctx"}, {33'h0, xctx_r, xctx_badvpn2}, {33'h0, e.xr, e.xbv});
        chk({e.tag, " R7 entryhi"}, {35'h0, entryhi_r, entryhi_vpn2}, {35'h0, e.hr, e.vpn});
      end
    end
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R12 reset state
    chk("R12 status", {32'h0, status}, 64'h0040_0000);
    chk("R12 cause", {32'h0, cause}, 64'h0);
    chk("R12 epc", epc, 64'h0);
    chk("R12 redir_valid", {63'h0, redir_valid}, 64'h0);

    // R11 R13 R1: seed cause, syscall at boot vector
    wr(1'b0, 32'h30FF_FF00);
    chk("R13 cause write", {32'h0, cause}, 64'h30FF_FF00);
    exc(1, 64'h1000, 1'b0, 64'hDEAD_0000, 64'h0, "R1 syscall");
    chk("R6 boot vector", redir_pc, 64'hFFFF_FFFF_BFC0_0380);
    // R4 R5: nested, capability trap uses common offset at EXL
    exc(17, 64'h5000, 1'b1, 64'h0, 64'h0, "R4 nested");
    chk("R4 epc held", epc, 64'h1000);

    // R3 R5 R6 R7: refill load in delay slot, normal base, capability base
    do_reset();
    wr(1'b1, 32'h0000_0000);
    exc(12, 64'h2000, 1'b1, 64'hC000_0012_3456_7000, 64'h100, "R5 refill");
    chk("R6 refill target", redir_pc, 64'hFFFF_FFFF_7FFF_FF80);
    chk("R3 delay epc", epc, 64'h1FFC);

    // R5: capability trap with EXL clear, wrapping capability base
    do_reset();
    exc(17, 64'h3000, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R5 captrap");
    do_reset();
    exc(13, 64'h4000, 1'b0, 64'h8000_00AB_CDEF_2000, 64'h0, "R7 refill store");
    do_reset();
    exc(7, 64'h4100, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0, "R7 addr err");
    do_reset();
    exc(9, 64'h4200, 1'b1, 64'h7FFF_FF00_1122_3344, 64'h40, "R7 tlb mod");
    for (int c = 0; c < 19; c++) begin
      do_reset();
      exc(c, 64'h8000 + 64'(c * 16), c[0], 64'hA5A5_0000_0000_1000 + 64'(c), 64'h0, "R1 sweep");
    end

    // R8 R9: user mode with CU0 clear raises coprocessor unusable
    do_reset();
    wr(1'b0, 32'h3000_0100);
    wr(1'b1, 32'h0040_0010);
    chk("R8 user", {62'h0, priv_level}, 64'd2);
    acc(64'h6000, "R9 violation");
    chk("R9 CE cleared", {62'h0, cause[29:28]}, 64'h0);
    chk("R8 kernel at exl", {62'h0, priv_level}, 64'd0);
    acc(64'h6004, "R9 kernel ignored");
    chk("R9 no redirect at kernel", {63'h0, redir_valid}, 64'h0);

    // R8 R9: supervisor with CU0 set ignored; KSU 11 is user; ERL forces kernel
    do_reset();
    wr(1'b1, 32'h1040_0008);
    chk("R8 supervisor", {62'h0, priv_level}, 64'd1);
    acc(64'h6100, "R9 cu0 ignored");
    chk("R9 no redirect with CU0", {63'h0, redir_valid}, 64'h0);
    chk("R9 status unchanged", {32'h0, status}, 64'h1040_0008);
    wr(1'b1, 32'h0040_0018);
    chk("R8 ksu11 user", {62'h0, priv_level}, 64'd2);
    wr(1'b1, 32'h0040_0014);
    chk("R8 erl kernel", {62'h0, priv_level}, 64'd0);

    // R10: violation and overflow request together
    do_reset();
    wr(1'b0, 32'h2000_0000);
    wr(1'b1, 32'h0040_0010);
    drive(1'b1, 4, 64'h7000, 1'b0, 64'h0, 64'h0, 1'b1, 1'b0, 1'b0, 32'h0, "R10 priority");
    chk("R10 overflow code", {59'h0, cause[6:2]}, 64'h0C);
    chk("R10 CE kept", {62'h0, cause[29:28]}, 64'h2);

    // R13: write colliding with entry is dropped
    do_reset();
    drive(1'b1, 2, 64'h7100, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1, 1'b1, 32'h0000_0000, "R13 collide");
    chk("R13 write dropped", {32'h0, status}, 64'h0040_0002);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 64'(q.size()), 64'h0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule